// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers event pulses from on-chip sources into a 32-bit sticky cause register and drives one level-sensitive interrupt line towards the host. The host reads the cause register to learn why it was interrupted, and acknowledges causes by writing 1s to them. A 32-bit enable register chooses which causes are allowed to interrupt.

The line is not raised as soon as an enabled cause appears. A coalescing timer, programmed in units of a fixed tick (nominally 32 µs, set by a clock-cycle parameter), delays it so that a burst of events costs the host a single interrupt. An urgent receive event skips the delay. A second programmable field produces a periodic receive cause. Status pulses from a DMA engine are folded into the main receive, transmit and error causes.

Top module: `irq_coalescer`

## Requirements
- R1: Writing the status register (address 0) clears every status bit written as 1 and leaves every bit written as 0 unchanged; nothing else clears a status bit.
- R2: A pulse on `cause_set_i[n]` sets status bit n, visible one cycle later whatever the enable register holds; a status bit whose enable bit is 0 never raises `host_irq_o`.
- R3: When a hardware set and a host clear hit the same status bit in one cycle, the bit ends up set.
- R4: With a coalescing value C > 0 and the line idle, an enabled cause latched at clock edge k raises `host_irq_o` at edge k+1+C·TICK_CYCLES, and not earlier.
- R5: With a coalescing value of 0, an enabled cause latched at edge k raises `host_irq_o` at edge k+1.
- R6: Once high, `host_irq_o` stays high while any enabled status bit remains set, and falls at the edge after the write that clears the last one.
- R7: An urgent receive pulse (`hipri_rx_i`, or `dma_evt_i[4]`) sets status bit 31 and, when enable bit 31 is 1, raises `host_irq_o` at the same edge, whatever the coalescing value.
- R8: DMA pulses fold into status bits: `dma_evt_i[1:0]` (transmit channels) set bit 27, `dma_evt_i[3:2]` (receive channels) and `dma_evt_i[4]` set bit 31, `dma_evt_i[5]` (engine error) sets bit 29.
- R9: A nonzero periodic value N in bits 15:8 of address 2 sets status bit 28 every N ticks, the first time N·TICK_CYCLES edges after the write; a value of 0 stops it.
- R10: Address 0 is status, 1 is enable, 2 holds the coalescing value in bits 7:0 and the periodic value in bits 15:8, 3 reads 0. After reset: status 0, enable 0, coalescing 0x40, periodic 0, `host_irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_set_i | input | 32 | One-cycle event pulses, one per status bit |
| dma_evt_i | input | 6 | DMA engine pulses: tx0, tx1, rx0, rx1, urgent rx, error |
| hipri_rx_i | input | 1 | Urgent receive pulse that skips coalescing |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| host_irq_o | output | 1 | Level interrupt to the host |

## Verification
Status bits appear one edge after a pulse, and a write takes effect at the edge that samples the strobe. The line is due one edge after the cause with no coalescing, C·TICK_CYCLES edges after that with coalescing, at the cause edge itself for urgent receive, and one edge after the clearing write on the way down. Inputs are driven and outputs sampled on the falling clock edge, so the bench counts rising edges exactly and checks the line both one cycle before and in the cycle its change is due; the periodic cause is checked the same way around its N·TICK_CYCLES point.

// File: rtl/irq_coalescer_pkg.sv
package irq_coalescer_pkg;

   localparam int REG_W = 32;
   localparam int TIM_W = 8;

   // status bit positions that the block itself drives
   localparam int CB_RX_DMA   = 31;
   localparam int CB_DMA_ERR  = 29;
   localparam int CB_PERIODIC = 28;
   localparam int CB_TX_DMA   = 27;

   typedef enum logic [1:0] {
      RA_STATUS = 2'd0,
      RA_ENABLE = 2'd1,
      RA_TIMING = 2'd2,
      RA_SPARE  = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic err;
      logic urgent_rx;
      logic rx1;
      logic rx0;
      logic tx1;
      logic tx0;
   } dma_evt_t;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_WAIT  = 2'd1,
      CS_FIRED = 2'd2
   } coal_state_e;

endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
   parameter int TICK_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
   localparam logic [PW-1:0] STEP = PW'(1);

   logic [PW-1:0] presc_q;

   assign tick = !restart && (presc_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         presc_q <= '0;
      else if (restart || tick)
         presc_q <= '0;
      else
         presc_q <= presc_q + STEP;
   end
endmodule

// File: rtl/irq_status_w1c.sv
module irq_status_w1c #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] status
);
   logic [WIDTH-1:0] nxt;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      // a hardware set outranks a host clear on the same bit
      assign nxt[b] = set_vec[b] | (status[b] & ~clr_vec[b]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= '0;
      else
         status <= nxt;
   end
endmodule

// File: rtl/irq_periodic.sv
module irq_periodic #(
   parameter int TICK_CYCLES = 32,
   parameter int PER_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PER_W-1:0] period,
   output logic             fire
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   logic             enabled;
   logic             tick;
   logic [PER_W-1:0] cnt_q;

   assign enabled = (period != '0);

   irq_tick_div #(.TICK_CYCLES(TICK_CYCLES)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart || !enabled),
      .tick    (tick)
   );

   assign fire = tick && (cnt_q == (period - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || !enabled)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= fire ? '0 : cnt_q + ONE;
   end
endmodule

// File: rtl/irq_coal_fsm.sv
module irq_coal_fsm
   import irq_coalescer_pkg::*;
#(
   parameter int TICK_CYCLES = 32,
   parameter int CNT_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pending,
   input  logic             urgent,
   input  logic [CNT_W-1:0] coal_val,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   coal_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             tick;

   irq_tick_div #(.TICK_CYCLES(TICK_CYCLES)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_q != CS_WAIT),
      .tick    (tick)
   );

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         CS_IDLE: begin
            cnt_d = coal_val;
            if (urgent || (pending && coal_val == '0))
               state_d = CS_FIRED;
            else if (pending)
               state_d = CS_WAIT;
         end
         CS_WAIT: begin
            if (urgent || coal_val == '0)
               state_d = CS_FIRED;
            else if (!pending)
               state_d = CS_IDLE;
            else if (tick) begin
               if (cnt_q == ONE)
                  state_d = CS_FIRED;
               else
                  cnt_d = cnt_q - ONE;
            end
         end
         CS_FIRED: begin
            if (!pending && !urgent)
               state_d = CS_IDLE;
         end
         default: state_d = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign irq = (state_q == CS_FIRED);
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
   import irq_coalescer_pkg::*;
#(
   parameter int          TICK_CYCLES = 4000,
   parameter logic [7:0]  COAL_RESET  = 8'h40
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] cause_set_i,
   input  logic [5:0]  dma_evt_i,
   input  logic        hipri_rx_i,
   input  logic        reg_wr_i,
   input  logic [1:0]  reg_addr_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   output logic        host_irq_o
);
   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("irq_coalescer: TICK_CYCLES must be at least 1");
   end
   if ($bits(dma_evt_t) != 6) begin : g_bad_dma
      $error("irq_coalescer: DMA event layout must be 6 bits");
   end

   dma_evt_t         dma;
   logic [REG_W-1:0] status_q, mask_q, set_vec, clr_vec, dma_fold;
   logic [TIM_W-1:0] coal_q, per_q;
   logic             hi_now, per_fire, pending, timing_wr;

   assign dma       = dma_evt_t'(dma_evt_i);
   assign hi_now    = hipri_rx_i | dma.urgent_rx;
   assign timing_wr = reg_wr_i && (reg_addr_e'(reg_addr_i) == RA_TIMING);

   always_comb begin
      dma_fold              = '0;
      dma_fold[CB_RX_DMA]   = dma.rx0 | dma.rx1 | hi_now;
      dma_fold[CB_TX_DMA]   = dma.tx0 | dma.tx1;
      dma_fold[CB_DMA_ERR]  = dma.err;
      dma_fold[CB_PERIODIC] = per_fire;
   end

   assign set_vec = cause_set_i | dma_fold;
   assign clr_vec = (reg_wr_i && reg_addr_e'(reg_addr_i) == RA_STATUS) ? reg_wdata_i : '0;

   irq_status_w1c #(.WIDTH(REG_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .status  (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         coal_q <= COAL_RESET;
         per_q  <= '0;
      end else if (reg_wr_i) begin
         if (reg_addr_e'(reg_addr_i) == RA_ENABLE)
            mask_q <= reg_wdata_i;
         if (timing_wr) begin
            coal_q <= reg_wdata_i[TIM_W-1:0];
            per_q  <= reg_wdata_i[2*TIM_W-1:TIM_W];
         end
      end
   end

   always_comb begin
      unique case (reg_addr_e'(reg_addr_i))
         RA_STATUS: reg_rdata_o = status_q;
         RA_ENABLE: reg_rdata_o = mask_q;
         RA_TIMING: reg_rdata_o = {{(REG_W-2*TIM_W){1'b0}}, per_q, coal_q};
         default:   reg_rdata_o = '0;
      endcase
   end

   irq_periodic #(.TICK_CYCLES(TICK_CYCLES), .PER_W(TIM_W)) u_periodic (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (timing_wr),
      .period  (per_q),
      .fire    (per_fire)
   );

   assign pending = |(status_q & mask_q);

   irq_coal_fsm #(.TICK_CYCLES(TICK_CYCLES), .CNT_W(TIM_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pending  (pending),
      .urgent   (hi_now && mask_q[CB_RX_DMA]),
      .coal_val (coal_q),
      .irq      (host_irq_o)
   );
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        irq,
   input logic        wr,
   input logic [1:0]  addr,
   input logic [31:0] status,
   input logic [31:0] mask,
   input logic [7:0]  coal,
   input logic [31:0] set_vec,
   input logic        hi_now
);
   logic pend;
   assign pend = |(status & mask);

   AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr && addr == 2'd0) |-> ((status & $past(status)) == $past(status))); // R1

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != 32'd0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R3

   AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(pend) || $past(hi_now && mask[31]))); // R4

   AST_ZERO_COAL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && pend && coal == 8'd0) |=> irq); // R5

   AST_FALL_ONLY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> !$past(pend)); // R6

   AST_URGENT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_now && mask[31]) |=> irq); // R7
endmodule

bind irq_coalescer irq_coalescer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (host_irq_o),
   .wr      (reg_wr_i),
   .addr    (reg_addr_i),
   .status  (status_q),
   .mask    (mask_q),
   .coal    (coal_q),
   .set_vec (set_vec),
   .hi_now  (hi_now)
);

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
   localparam int TICK = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cause_set_i = '0;
   logic [5:0]  dma_evt_i = '0;
   logic        hipri_rx_i = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [1:0]  reg_addr_i = '0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        host_irq_o;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   irq_coalescer #(.TICK_CYCLES(TICK), .COAL_RESET(8'h40)) uut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0; reg_wdata_i = '0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      reg_addr_i = a;
      #1 d = reg_rdata_o;
   endtask

   task automatic pulse(logic [31:0] c);
      cause_set_i = c;
      @(negedge clk);
      cause_set_i = '0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd0, v); check("R10 status reset", v, 32'h0);
      rd(2'd1, v); check("R10 enable reset", v, 32'h0);
      rd(2'd2, v); check("R10 timing reset", v, 32'h0000_0040);
      rd(2'd3, v); check("R10 spare reads 0", v, 32'h0);
      check("R10 irq reset", {31'd0, host_irq_o}, 32'd0);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      pulse(32'h0000_0041);
      rd(2'd0, v); check("R2 masked causes latch", v, 32'h0000_0041);
      idle(3);
      check("R2 disabled causes keep irq low", {31'd0, host_irq_o}, 32'd0);
      wr(2'd0, 32'h0000_0001);
      rd(2'd0, v); check("R1 write 1 clears", v, 32'h0000_0040);
      wr(2'd0, 32'h0000_0000);
      rd(2'd0, v); check("R1 write 0 keeps", v, 32'h0000_0040);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R1 clear all", v, 32'h0);
   endtask

   task automatic t_zero_coal();
      wr(2'd2, 32'h0);
      wr(2'd1, 32'h0000_000C);
      pulse(32'h0000_0008);
      check("R5 low at cause edge", {31'd0, host_irq_o}, 32'd0);
      idle(1);
      check("R5 high one edge later", {31'd0, host_irq_o}, 32'd1);
      pulse(32'h0000_0004);
      wr(2'd0, 32'h0000_0008);
      check("R6 stays high with one enabled left", {31'd0, host_irq_o}, 32'd1);
      wr(2'd0, 32'h0000_0004);
      check("R6 high right after last clear", {31'd0, host_irq_o}, 32'd1);
      idle(1);
      check("R6 low one edge after clear", {31'd0, host_irq_o}, 32'd0);
   endtask

   task automatic t_coal();
      wr(2'd2, 32'h0000_0003);
      wr(2'd1, 32'h0000_0001);
      pulse(32'h0000_0001);
      idle(3 * TICK);
      check("R4 still low one edge early", {31'd0, host_irq_o}, 32'd0);
      idle(1);
      check("R4 high after C ticks", {31'd0, host_irq_o}, 32'd1);
      wr(2'd0, 32'h0000_0001);
      idle(1);
      check("R6 drops after coalesced clear", {31'd0, host_irq_o}, 32'd0);
   endtask

   task automatic t_urgent();
      logic [31:0] v;
      wr(2'd2, 32'h0000_00FF);
      wr(2'd1, 32'h8000_0000);
      hipri_rx_i = 1'b1;
      @(negedge clk);
      hipri_rx_i = 1'b0;
      check("R7 irq at urgent edge", {31'd0, host_irq_o}, 32'd1);
      rd(2'd0, v); check("R7 urgent sets bit 31", v, 32'h8000_0000);
      wr(2'd0, 32'h8000_0000);
      idle(1);
      check("R7 irq clears", {31'd0, host_irq_o}, 32'd0);
      dma_evt_i = 6'b010000;
      @(negedge clk);
      dma_evt_i = '0;
      check("R7 DMA urgent bypass", {31'd0, host_irq_o}, 32'd1);
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd1, 32'h0);
      idle(1);
   endtask

   task automatic t_set_wins();
      logic [31:0] v;
      pulse(32'h0000_0002);
      cause_set_i = 32'h0000_0002;
      reg_wr_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'h0000_0002;
      @(negedge clk);
      cause_set_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
      rd(2'd0, v); check("R3 set beats clear", v, 32'h0000_0002);
      wr(2'd0, 32'h0000_0002);
      rd(2'd0, v); check("R3 plain clear afterwards", v, 32'h0);
   endtask

   task automatic t_dma();
      logic [31:0] v;
      dma_evt_i = 6'b100101;
      @(negedge clk);
      dma_evt_i = '0;
      rd(2'd0, v); check("R8 fold err rx0 tx0", v, 32'hA800_0000);
      wr(2'd0, 32'hFFFF_FFFF);
      dma_evt_i = 6'b001010;
      @(negedge clk);
      dma_evt_i = '0;
      rd(2'd0, v); check("R8 fold rx1 tx1", v, 32'h8800_0000);
      wr(2'd0, 32'hFFFF_FFFF);
   endtask

   task automatic t_periodic();
      logic [31:0] v;
      wr(2'd2, 32'h0000_0200);
      idle(2 * TICK - 1);
      rd(2'd0, v); check("R9 not yet at N*TICK-1", v, 32'h0);
      idle(1);
      rd(2'd0, v); check("R9 periodic sets bit 28", v, 32'h1000_0000);
      wr(2'd2, 32'h0000_0000);
      wr(2'd0, 32'h1000_0000);
      idle(20);
      rd(2'd0, v); check("R9 zero stops periodic", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_w1c();
      t_zero_coal();
      t_coal();
      t_urgent();
      t_set_wins();
      t_dma();
      t_periodic();
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule